// File: doc/BRIEF.md
# DRAM Refresh and Power-On Scheduler

This block produces all of the housekeeping traffic that an asynchronous DRAM with 2,048 refresh rows needs. When reset is released it waits out the power-up pause. It then runs a train of eight wake-up cycles, each of which contains a RAS pulse. Only after that does it report the memory as ready. From then on it issues CAS-before-RAS (CBR) refreshes, one per refresh interval, so that every row is refreshed inside the retention window. In a CBR cycle CAS goes low before RAS, so the address pins play no part.

The scheduler shares the RAS and CAS strobes with an access sequencer through a request/grant pair. While the access side holds the grant, any refresh that falls due is counted as owed instead of being issued. The owed refreshes are issued back to back once the bus is released. When the owed count reaches a limit, new grants are held back until the count falls again. If the count ever passes a larger deadline, the retention guarantee is treated as lost. In that case the ready flag drops and the eight-cycle wake-up train is repeated.

A self-refresh request parks the DRAM in its low-power retention mode. The scheduler starts a CBR cycle and holds RAS low for as long as the request stays high. On exit it keeps RAS high for the self-refresh precharge time before anything else may use the strobes. All delays are parameters in clock cycles. A shortened-time switch replaces the long pause and the long interval for simulation.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is held low, and on the first cycle after reset, ras_n and cas_n are 1 and acc_gnt, rfsh_own, ready and self_on are 0.
- R2: ras_n does not fall during the first pause period after reset. The pause period is PAUSE_CYC cycles, or SIM_PAUSE cycles when SIM_SHORT is 1.
- R3: After the pause, exactly WAKE_N (8) RAS cycles take place before ready rises. acc_gnt never rises while ready is 0.
- R4: Every fall of ras_n is a CBR cycle. cas_n has already been 0 for at least T_CSR cycles when ras_n falls, and it stays 0 for at least T_CHR cycles after the fall.
- R5: ras_n stays low for at least T_RAS cycles and stays high for at least T_RP cycles between cycles. cas_n stays high for at least T_RPC cycles after ras_n rises. While rfsh_own is 0, both strobes are 1.
- R6: With no access traffic, one refresh is issued every refresh interval. The interval is TREFI_CYC cycles, or SIM_TREFI cycles when SIM_SHORT is 1.
- R7: acc_gnt and rfsh_own are never 1 together. A request that arrives while refreshes are owed, but fewer than MAX_PEND, is granted before those refreshes are issued.
- R8: Refreshes that fall due while the access side holds the grant are issued back to back after it releases the bus.
- R9: While MAX_PEND or more refreshes are owed, a new request is not granted until a refresh has been issued.
- R10: If a refresh falls due while MISS_PEND are already owed, ready goes to 0. After the access side releases, exactly WAKE_N RAS cycles take place, and then ready returns to 1.
- R11: When sr_req is 1 and nothing is owed, a CBR cycle starts and RAS stays low while sr_req stays 1. self_on rises no earlier than T_RASS cycles after RAS falls. No grant is given and no further RAS fall occurs in self refresh.
- R12: After sr_req drops, RAS stays high for at least T_RPS cycles before the bus is granted or a new cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_req | input | 1 | Access sequencer asks for the strobes; dropping it releases the bus |
| sr_req | input | 1 | Level request for self-refresh mode |
| acc_gnt | output | 1 | Access sequencer owns RAS/CAS |
| rfsh_own | output | 1 | Scheduler is driving RAS/CAS |
| ras_n | output | 1 | Row strobe, active low, valid while rfsh_own is 1 |
| cas_n | output | 1 | Column strobe, active low, valid while rfsh_own is 1 |
| ready | output | 1 | Start-up complete and retention intact; normal access allowed |
| self_on | output | 1 | DRAM is in self refresh |

## Verification
Two functions can be live in the same cycle: an access request and a refresh that is already owed. The bench sets this up by keeping the grant through several refresh intervals, so that the owed count reaches its limit. It then releases the bus and raises the request again on the very next cycle. The forced refresh must come first. As soon as the owed count is below the limit, the waiting request must win the grant ahead of the refreshes that are still owed, and those must then follow right after the release. Strobe monitors running on every cycle check the CBR setup, hold and precharge spacing, and confirm that the grant and the scheduler's ownership never overlap.

// File: rtl/rfsh_pkg.sv
// Shared types for the DRAM refresh scheduler.
package rfsh_pkg;
    // Top-level operating phase of the scheduler.
    typedef enum logic [1:0] {
        M_PAUSE = 2'd0,
        M_WAKE  = 2'd1,
        M_RUN   = 2'd2,
        M_SELF  = 2'd3
    } mode_t;

    // Phase of one strobe cycle generated by the sequencer.
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_CSU  = 3'd1,
        S_CHR  = 3'd2,
        S_RASL = 3'd3,
        S_SELF = 3'd4,
        S_PRE  = 3'd5
    } seq_t;
endpackage

// File: rtl/rfsh_tick.sv
// Interval timer: emits a one-cycle pulse every PERIOD enabled cycles.
// Assumes PERIOD >= 2. The count restarts from zero whenever en is low.
module rfsh_tick #(
    parameter int PERIOD = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt;

    // Free-running count that wraps at PERIOD-1 while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)              cnt <= '0;
        else if (cnt == CW'(PERIOD-1))  cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == CW'(PERIOD-1));
endmodule

// File: rtl/rfsh_pend.sv
// Owed-refresh counter. It counts interval ticks up and issued refreshes
// down, flags the forcing limit, and flags a missed deadline when a tick
// arrives with MISS_PEND already owed. Assumes MISS_PEND > MAX_PEND >= 1.
module rfsh_pend #(
    parameter int MAX_PEND  = 4,
    parameter int MISS_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic owed,
    output logic forced,
    output logic miss
);
    localparam int PW = $clog2(MISS_PEND + 1);

    logic [PW-1:0] cnt;
    logic          up, down;

    assign miss   = inc && (cnt == PW'(MISS_PEND));
    assign up     = inc && !miss;
    assign down   = dec && (cnt != '0);
    assign owed   = (cnt != '0);
    assign forced = (cnt >= PW'(MAX_PEND));

    // Net count update; a simultaneous tick and issue cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       cnt <= '0;
        else if (up && !down)    cnt <= cnt + 1'b1;
        else if (down && !up)    cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/rfsh_seq.sv
// Strobe sequencer for one CBR cycle: CAS setup, RAS fall with CAS held,
// the rest of the RAS low time, then precharge. If hold_self is high when
// the CAS hold ends, RAS stays low as self refresh for at least T_RASS
// cycles, and the precharge after it uses T_RPS.
// Assumes T_RAS > T_CHR and all times >= 1.
module rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int T_CSR  = 2,
    parameter int T_CHR  = 2,
    parameter int T_RAS  = 8,
    parameter int T_RP   = 5,
    parameter int T_RPC  = 2,
    parameter int T_RASS = 12500,
    parameter int T_RPS  = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold_self,
    output logic busy,
    output logic done,
    output logic self_act,
    output logic ras_n,
    output logic cas_n
);
    localparam int T_PRE = (T_RP > T_RPC) ? T_RP : T_RPC;
    localparam int M1    = (T_RASS > T_RPS) ? T_RASS : T_RPS;
    localparam int M2    = (T_PRE > T_RAS) ? T_PRE : T_RAS;
    localparam int M3    = (M1 > M2) ? M1 : M2;
    localparam int TMAX  = (M3 > T_CSR) ? M3 : T_CSR;
    localparam int TW    = $clog2(TMAX + 1);

    seq_t          st;
    logic [TW-1:0] cnt;

    // Phase and phase-timer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    st  <= S_CSU;
                    cnt <= TW'(T_CSR - 1);
                end
                S_CSU: if (cnt == '0) begin
                    st  <= S_CHR;
                    cnt <= TW'(T_CHR - 1);
                end else cnt <= cnt - 1'b1;
                S_CHR: if (cnt == '0) begin
                    if (hold_self) begin
                        st  <= S_SELF;
                        cnt <= TW'(T_RASS - T_CHR - 1);
                    end else begin
                        st  <= S_RASL;
                        cnt <= TW'(T_RAS - T_CHR - 1);
                    end
                end else cnt <= cnt - 1'b1;
                S_RASL: if (cnt == '0) begin
                    st  <= S_PRE;
                    cnt <= TW'(T_PRE - 1);
                end else cnt <= cnt - 1'b1;
                S_SELF: if (cnt != '0) cnt <= cnt - 1'b1;
                else if (!hold_self) begin
                    st  <= S_PRE;
                    cnt <= TW'(T_RPS - 1);
                end
                S_PRE: if (cnt == '0) st <= S_IDLE;
                       else cnt <= cnt - 1'b1;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy     = (st != S_IDLE);
    assign done     = (st == S_PRE) && (cnt == '0);
    assign self_act = (st == S_SELF) && (cnt == '0);
    assign ras_n    = !((st == S_CHR) || (st == S_RASL) || (st == S_SELF));
    assign cas_n    = !((st == S_CSU) || (st == S_CHR) || (st == S_SELF));
endmodule

// File: rtl/dram_rfsh_sched.sv
// DRAM refresh and power-on scheduler. It sequences the power-up pause and
// the wake-up train, then spreads CBR refreshes evenly. It arbitrates the
// strobes with an access sequencer and offers self refresh.
// Assumes the access side drives no strobe unless acc_gnt is 1, and keeps
// acc_req high for as long as it wants the bus.
module dram_rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int PAUSE_CYC = 25000,
    parameter int TREFI_CYC = 1950,
    parameter bit SIM_SHORT = 1'b0,
    parameter int SIM_PAUSE = 64,
    parameter int SIM_TREFI = 100,
    parameter int WAKE_N    = 8,
    parameter int MAX_PEND  = 4,
    parameter int MISS_PEND = 8,
    parameter int T_CSR     = 2,
    parameter int T_CHR     = 2,
    parameter int T_RAS     = 8,
    parameter int T_RP      = 5,
    parameter int T_RPC     = 2,
    parameter int T_RASS    = 12500,
    parameter int T_RPS     = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_req,
    input  logic sr_req,
    output logic acc_gnt,
    output logic rfsh_own,
    output logic ras_n,
    output logic cas_n,
    output logic ready,
    output logic self_on
);
    localparam int PAUSE_EFF = SIM_SHORT ? SIM_PAUSE : PAUSE_CYC;
    localparam int TREFI_EFF = SIM_SHORT ? SIM_TREFI : TREFI_CYC;
    localparam int PW        = $clog2(PAUSE_EFF + 1);
    localparam int WW        = $clog2(WAKE_N + 1);

    mode_t         mode;
    logic [PW-1:0] pcnt;
    logic [WW-1:0] wcnt;
    logic          gnt_q;
    logic          tick, owed, forced, miss;
    logic          seq_busy, seq_done;
    logic          start_wake, start_ref, start_self, gnt_set;

    rfsh_tick #(.PERIOD(TREFI_EFF)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(mode == M_RUN), .tick(tick)
    );

    rfsh_pend #(.MAX_PEND(MAX_PEND), .MISS_PEND(MISS_PEND)) u_pend (
        .clk(clk), .rst_n(rst_n), .clr(mode != M_RUN), .inc(tick),
        .dec(seq_done && (mode == M_RUN)),
        .owed(owed), .forced(forced), .miss(miss)
    );

    rfsh_seq #(
        .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP),
        .T_RPC(T_RPC), .T_RASS(T_RASS), .T_RPS(T_RPS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start_wake || start_ref || start_self),
        .hold_self(sr_req && (mode == M_SELF)),
        .busy(seq_busy), .done(seq_done), .self_act(self_on),
        .ras_n(ras_n), .cas_n(cas_n)
    );

    // Bus arbitration: access wins unless the owed count is at its limit
    // or self refresh is wanted.
    assign start_wake = (mode == M_WAKE) && !seq_busy && !gnt_q;
    assign start_ref  = (mode == M_RUN) && !seq_busy && !gnt_q && owed &&
                        (!acc_req || forced || sr_req);
    assign start_self = (mode == M_RUN) && !seq_busy && !gnt_q && !owed && sr_req;
    assign gnt_set    = (mode == M_RUN) && acc_req && !seq_busy && !sr_req && !forced;

    // Grant register: held while the access side keeps requesting.
    always_ff @(posedge clk) begin
        if (!rst_n) gnt_q <= 1'b0;
        else        gnt_q <= gnt_q ? acc_req : gnt_set;
    end

    // Phase control: pause, wake train, normal run, self refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= M_PAUSE;
            pcnt <= '0;
            wcnt <= '0;
        end else begin
            case (mode)
                M_PAUSE: if (pcnt == PW'(PAUSE_EFF - 1)) begin
                    mode <= M_WAKE;
                    wcnt <= '0;
                end else pcnt <= pcnt + 1'b1;
                M_WAKE: if (seq_done) begin
                    if (wcnt == WW'(WAKE_N - 1)) mode <= M_RUN;
                    else                         wcnt <= wcnt + 1'b1;
                end
                M_RUN: if (miss) begin
                    mode <= M_WAKE;
                    wcnt <= '0;
                end else if (start_self) mode <= M_SELF;
                M_SELF: if (seq_done) mode <= M_RUN;
                default: mode <= M_PAUSE;
            endcase
        end
    end

    assign acc_gnt  = gnt_q;
    assign rfsh_own = seq_busy;
    assign ready    = (mode == M_RUN);
endmodule

// File: rtl/dram_rfsh_sched_chk.sv
// Property checker for dram_rfsh_sched, attached by bind below.
// Assumes only the top-level ports and parameters of the scheduler.
module dram_rfsh_sched_chk #(
    parameter int PAUSE_CYC = 25000,
    parameter bit SIM_SHORT = 1'b0,
    parameter int SIM_PAUSE = 64
) (
    input logic clk,
    input logic rst_n,
    input logic acc_gnt,
    input logic rfsh_own,
    input logic ras_n,
    input logic cas_n,
    input logic ready,
    input logic self_on
);
    localparam int PAUSE_EFF = SIM_SHORT ? SIM_PAUSE : PAUSE_CYC;

    int unsigned since_rst;

    // Cycles since reset release, saturating once the pause is over.
    always_ff @(posedge clk) begin
        if (!rst_n)                      since_rst <= 0;
        else if (since_rst < PAUSE_EFF)  since_rst <= since_rst + 1;
    end

    p_pause_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (since_rst >= PAUSE_EFF));

    p_gnt_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_gnt) |-> ready);

    p_cbr_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

    p_idle_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_own |-> (ras_n && cas_n));

    p_bus_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> !rfsh_own);

    p_self_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        self_on |-> (!ras_n && !acc_gnt && !ready));
endmodule

bind dram_rfsh_sched dram_rfsh_sched_chk #(
    .PAUSE_CYC(PAUSE_CYC), .SIM_SHORT(SIM_SHORT), .SIM_PAUSE(SIM_PAUSE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_gnt(acc_gnt), .rfsh_own(rfsh_own),
    .ras_n(ras_n), .cas_n(cas_n), .ready(ready), .self_on(self_on)
);

// File: tb/dram_rfsh_sched_tb.sv
// Directed bench for dram_rfsh_sched with shortened timing.
module dram_rfsh_sched_tb;
    localparam int PAUSE  = 40;
    localparam int TREFI  = 60;
    localparam int WAKE   = 8;
    localparam int T_CSR  = 2;
    localparam int T_CHR  = 2;
    localparam int T_RAS  = 8;
    localparam int T_RP   = 5;
    localparam int T_RPC  = 2;
    localparam int T_RASS = 30;
    localparam int T_RPS  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_req = 1'b0;
    logic sr_req = 1'b0;
    logic acc_gnt, rfsh_own, ras_n, cas_n, ready, self_on;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int falls = 0;
    int v4 = 0, v5 = 0, v7 = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dram_rfsh_sched #(
        .SIM_SHORT(1'b1), .SIM_PAUSE(PAUSE), .SIM_TREFI(TREFI),
        .WAKE_N(WAKE), .MAX_PEND(4), .MISS_PEND(8),
        .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP),
        .T_RPC(T_RPC), .T_RASS(T_RASS), .T_RPS(T_RPS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .sr_req(sr_req),
        .acc_gnt(acc_gnt), .rfsh_own(rfsh_own), .ras_n(ras_n),
        .cas_n(cas_n), .ready(ready), .self_on(self_on)
    );

    // Strobe monitor, sampled mid-cycle: counts RAS falls and timing faults.
    logic p_ras = 1'b1, p_cas = 1'b1;
    int ras_lo = 0, ras_hi = 0, cas_lo = 0, fall_cyc = 0;
    bit had_rise = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc <= cyc + 1;
            if (p_ras && !ras_n) begin
                falls <= falls + 1;
                fall_cyc <= cyc;
                if (cas_n || cas_lo < T_CSR) v4 <= v4 + 1;
                if (had_rise && ras_hi < T_RP) v5 <= v5 + 1;
            end
            if (!p_ras && ras_n) begin
                had_rise <= 1'b1;
                if (ras_lo < T_RAS) v5 <= v5 + 1;
            end
            if (!p_cas && cas_n && !ras_n && (cyc - fall_cyc) < T_CHR) v4 <= v4 + 1;
            if (p_cas && !cas_n && ras_n && had_rise && ras_hi < T_RPC) v5 <= v5 + 1;
            if (acc_gnt && (rfsh_own || !ras_n || !cas_n)) v7 <= v7 + 1;
            ras_lo <= ras_n ? 0 : ras_lo + 1;
            ras_hi <= ras_n ? ras_hi + 1 : 0;
            cas_lo <= cas_n ? 0 : cas_lo + 1;
            p_ras  <= ras_n;
            p_cas  <= cas_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready(input int lim);
        for (int i = 0; i < lim && !ready; i++) @(negedge clk);
    endtask

    // Reset values and the first cycle after reset (R1).
    task automatic t_reset();
        wait_cyc(3);
        chk(ras_n && cas_n && !acc_gnt && !rfsh_own && !ready && !self_on,
            "R1 in reset", {ras_n, cas_n, acc_gnt, rfsh_own, ready, self_on}, 6'b110000);
        rst_n = 1'b1;
        wait_cyc(1);
        chk(ras_n && cas_n && !acc_gnt && !rfsh_own && !ready,
            "R1 after reset", {ras_n, cas_n, acc_gnt, rfsh_own, ready}, 5'b11000);
    endtask

    // Pause then wake train; a pending request must not be granted early (R2, R3).
    task automatic t_startup();
        int first = -1;
        bit early_gnt = 0;
        acc_req = 1'b1;
        for (int i = 0; i < 400 && !ready; i++) begin
            @(negedge clk);
            if (first < 0 && falls > 0) first = cyc;
            if (acc_gnt) early_gnt = 1;
        end
        chk(first >= PAUSE && first <= PAUSE + 10, "R2 first RAS after pause", first, PAUSE);
        chk(ready == 1'b1 && falls == WAKE, "R3 wake cycles before ready", falls, WAKE);
        chk(!early_gnt, "R3 no grant before ready", early_gnt, 0);
        wait_cyc(2);
        chk(acc_gnt == 1'b1, "R7 grant after ready", acc_gnt, 1);
        acc_req = 1'b0;
        wait_cyc(3);
    endtask

    // Idle bus: one refresh per interval (R6).
    task automatic t_spread();
        int f0 = falls;
        wait_cyc(10 * TREFI);
        chk((falls - f0) >= 9 && (falls - f0) <= 11, "R6 refreshes per 10 intervals", falls - f0, 10);
    endtask

    // Refreshes owed during a grant come back to back after release (R8).
    task automatic t_postpone();
        int f0;
        wait_cyc(20);
        acc_req = 1'b1;
        wait_cyc(3);
        f0 = falls;
        wait_cyc(200);
        chk(falls == f0, "R7 no refresh while granted", falls - f0, 0);
        acc_req = 1'b0;
        f0 = falls;
        wait_cyc(80);
        chk((falls - f0) >= 3 && (falls - f0) <= 5, "R8 burst after release", falls - f0, 3);
        wait_cyc(40);
    endtask

    // Owed count at its limit: refresh first, then the request wins while
    // some refreshes are still owed (R9, R7).
    task automatic t_forced();
        int f0;
        acc_req = 1'b1;
        wait_cyc(3);
        wait_cyc(300);
        acc_req = 1'b0;
        wait_cyc(1);
        acc_req = 1'b1;
        f0 = falls;
        for (int i = 0; i < 200 && !acc_gnt; i++) @(negedge clk);
        chk(acc_gnt == 1'b1, "R9 request granted eventually", acc_gnt, 1);
        chk((falls - f0) >= 1 && (falls - f0) <= 3, "R9 forced refresh before grant", falls - f0, 1);
        wait_cyc(10);
        acc_req = 1'b0;
        f0 = falls;
        wait_cyc(20);
        chk((falls - f0) >= 1, "R7 owed refreshes follow release", falls - f0, 1);
        wait_cyc(80);
    endtask

    // Missed deadline: ready drops and the wake train repeats (R10).
    task automatic t_miss();
        int f0;
        acc_req = 1'b1;
        wait_cyc(3);
        wait_cyc(700);
        chk(ready == 1'b0, "R10 ready drops on missed deadline", ready, 0);
        chk(acc_gnt == 1'b1, "R10 grant kept until release", acc_gnt, 1);
        acc_req = 1'b0;
        f0 = falls;
        wait_ready(400);
        chk(ready == 1'b1 && (falls - f0) == WAKE, "R10 wake train repeated", falls - f0, WAKE);
        wait_cyc(5);
    endtask

    // Self refresh entry, hold and exit (R11, R12).
    task automatic t_self();
        int f0, lo, hi;
        sr_req = 1'b1;
        for (int i = 0; i < 300 && ras_n; i++) @(negedge clk);
        lo = 0;
        for (int i = 0; i < 300 && !self_on; i++) begin
            @(negedge clk);
            lo++;
        end
        chk(self_on == 1'b1 && lo >= T_RASS - 1, "R11 self_on after RAS time", lo, T_RASS);
        acc_req = 1'b1;
        f0 = falls;
        wait_cyc(40);
        chk(!ras_n && !acc_gnt && falls == f0, "R11 held in self refresh",
            {ras_n, acc_gnt}, 2'b00);
        chk(ready == 1'b0, "R11 not ready in self refresh", ready, 0);
        sr_req = 1'b0;
        for (int i = 0; i < 50 && !ras_n; i++) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 50 && !acc_gnt; i++) begin
            @(negedge clk);
            hi++;
            if (!ras_n) hi = -100;
        end
        chk(acc_gnt == 1'b1 && hi >= T_RPS, "R12 precharge after self refresh", hi, T_RPS);
        acc_req = 1'b0;
        wait_cyc(5);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_startup();
        t_spread();
        t_postpone();
        t_forced();
        t_miss();
        t_self();
        chk(v4 == 0, "R4 CBR setup and hold", v4, 0);
        chk(v5 == 0, "R5 strobe widths and precharge", v5, 0);
        chk(v7 == 0, "R7 grant and ownership exclusive", v7, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule